// File: doc/BRIEF.md
# SPI Register Target

This block is a four-wire SPI target that gives an external master read and write access to a bank of 64 eight-bit registers. The registers sit outside the block. The block drives an address, a write strobe and write data toward them, and takes combinational read data back.

The master pulls the active-low select low and toggles the serial clock, which idles high. It sends a command byte first, then one or more data bytes. The command byte holds a direction flag, an auto-increment flag and a 6-bit register address.

Chip select, serial clock and serial data in are brought into the system clock domain through synchronizers. The system clock runs at least eight times faster than the serial clock. The block finds the serial clock edges on the synchronized copy. It shifts data in on rising edges and shifts read data out on falling edges.

Top module: `spi_reg_target`

## Requirements
- R1: After reset, `sdoEn`, `sdo` and `regWrEn` are all 0.
- R2: The command byte is taken MSB first. Bit 7, the first bit sent, is the direction: 1 = read, 0 = write. Bit 6 is the auto-increment flag. Bits 5..0 are the register address. A read command causes no register write.
- R3: In a write frame, each complete data byte (MSB first, sampled on SPC rising edges) causes exactly one `regWrEn` pulse carrying that byte and the current address.
- R4: In a read frame, the register at the current address is shifted out on `sdo`, MSB first. Each bit changes after an SPC falling edge and is valid at the next rising edge.
- R5: With the auto-increment flag set to 1, the address steps by one after each data byte, wrapping from 63 to 0, for as long as CS stays low.
- R6: With the auto-increment flag at 0, every data byte of the frame uses the command's address.
- R7: `sdoEn` is 1 only while CS is low in the data phase of a read. Whenever `sdoEn` is 0, `sdo` is 0.
- R8: CS going high at any point ends the frame. A partly received byte is discarded without a write, and the next frame starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low, asynchronous |
| spc | input | 1 | Serial clock from the master, idles high |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial read data to the master |
| sdoEn | output | 1 | Output enable for `sdo` |
| regAddr | output | 6 | Register address |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Register write data |
| regRdData | input | 8 | Register read data for `regAddr` |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a 6-bit address and two synchronizer stages. The full 64-entry address space is therefore small enough to sweep completely with single-byte writes and reads. Expected bytes come from an arithmetic pattern of the address. Bursts that start at addresses 61 and 62 reach the wrap from 63 to 0. Frames are cut after 3 and 4 bits to exercise the abort in both the command phase and the data phase.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  // Strobes from control to datapath, at most a few active per cycle
  typedef struct packed {
    logic clearAll;
    logic shiftIn;
    logic loadCmd;
    logic commitWr;
    logic incAddr;
    logic loadOut;
    logic shiftOut;
  } ctrlStrb_t;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_tgt_ctrl.sv
module spi_tgt_ctrl
  import spi_tgt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csNS,
  input  logic              spcS,
  input  logic [BYTE_W-1:0] rxNext,
  output ctrlStrb_t         strb,
  output logic              sdoEn
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  typedef enum logic {PH_CMD, PH_DATA} phase_t;

  logic             spcPrev;
  logic [CNT_W-1:0] bitCnt;
  phase_t           phase;
  logic             isRead, isMulti;
  logic             csActive, spcRise, spcFall, byteDone, rdData;

  assign csActive = ~csNS;
  assign spcRise  = spcS & ~spcPrev;
  assign spcFall  = ~spcS & spcPrev;
  assign byteDone = csActive & spcRise & (bitCnt == LAST_BIT);
  assign rdData   = csActive & (phase == PH_DATA) & isRead;

  always_comb begin
    strb          = '0;
    strb.clearAll = ~csActive;
    strb.shiftIn  = csActive & spcRise;
    strb.loadCmd  = byteDone & (phase == PH_CMD);
    strb.commitWr = byteDone & (phase == PH_DATA) & ~isRead;
    strb.incAddr  = byteDone & (phase == PH_DATA) & isMulti;
    strb.loadOut  = rdData & spcFall & (bitCnt == '0);
    strb.shiftOut = rdData & spcFall & (bitCnt != '0);
  end

  assign sdoEn = rdData;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spcPrev <= 1'b1;
    else        spcPrev <= spcS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt  <= '0;
      phase   <= PH_CMD;
      isRead  <= 1'b0;
      isMulti <= 1'b0;
    end else if (!csActive) begin
      bitCnt  <= '0;
      phase   <= PH_CMD;
      isRead  <= 1'b0;
      isMulti <= 1'b0;
    end else if (spcRise) begin
      bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
      if (strb.loadCmd) begin
        phase   <= PH_DATA;
        isRead  <= rxNext[BYTE_W-1];
        isMulti <= rxNext[BYTE_W-2];
      end
    end
  end

  // R8
  bitcnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csActive |=> (bitCnt == '0) && (phase == PH_CMD));
  // R6
  fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.incAddr |-> isMulti);
  // R2
  no_write_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commitWr |-> !isRead && (phase == PH_DATA));
  // R7
  sdo_en_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdoEn |-> !csNS);
endmodule

// File: rtl/spi_tgt_dpath.sv
module spi_tgt_dpath
  import spi_tgt_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = BYTE_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrb_t         strb,
  input  logic              sdiS,
  input  logic [BYTE_W-1:0] regRdData,
  output logic [BYTE_W-1:0] rxNext,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  output logic              sdoBit
);
  logic [BYTE_W-1:0] shiftReg, outShift;
  logic [ADDR_W-1:0] addrReg;

  assign rxNext    = {shiftReg[BYTE_W-2:0], sdiS};
  assign regAddr   = addrReg;
  assign regWrEn   = strb.commitWr;
  assign regWrData = rxNext;
  assign sdoBit    = outShift[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             shiftReg <= '0;
    else if (strb.clearAll) shiftReg <= '0;
    else if (strb.shiftIn)  shiftReg <= rxNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            addrReg <= '0;
    else if (strb.loadCmd) addrReg <= rxNext[ADDR_W-1:0];
    else if (strb.incAddr) addrReg <= addrReg + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             outShift <= '0;
    else if (strb.loadOut)  outShift <= regRdData;
    else if (strb.shiftOut) outShift <= {outShift[BYTE_W-2:0], 1'b0};
  end

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addrReg != $past(addrReg)) && !$past(strb.loadCmd) |->
      addrReg == $past(addrReg) + 1'b1);
  // R3
  write_hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commitWr && !strb.incAddr |=> $stable(addrReg));
endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target
  import spi_tgt_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = BYTE_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csN,
  input  logic              spc,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  input  logic [BYTE_W-1:0] regRdData
);
  logic [2:0]        syncOut;
  logic              csNS, spcS, sdiS, sdoBit;
  logic [BYTE_W-1:0] rxNext;
  ctrlStrb_t         strb;

  spi_tgt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) sync_i (
    .clk(clk), .rst_n(rst_n), .din({csN, spc, sdi}), .dout(syncOut)
  );
  assign {csNS, spcS, sdiS} = syncOut;

  spi_tgt_ctrl #(.BYTE_W(BYTE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .csNS(csNS), .spcS(spcS),
    .rxNext(rxNext), .strb(strb), .sdoEn(sdoEn)
  );

  spi_tgt_dpath #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .sdiS(sdiS),
    .regRdData(regRdData), .rxNext(rxNext), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .sdoBit(sdoBit)
  );

  assign sdo = sdoEn & sdoBit;

  // R7
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdoEn |-> !sdo);
  // R3
  write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |-> !sdoEn);
endmodule

// File: tb/spi_reg_target_tb_top.sv
module spi_reg_target_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csN = 1'b1, spc = 1'b1, sdi = 1'b0;
  logic sdo, sdoEn, regWrEn;
  logic [5:0] regAddr;
  logic [7:0] regWrData, regRdData;

  logic [7:0] regMem [64];
  logic [7:0] expMem [64];
  int wrCount = 0;
  int nTests = 0, nFail = 0;
  logic enAny, enAll;
  bit done = 0;

  always #2 clk = ~clk;

  spi_reg_target dut_i (
    .clk(clk), .rst_n(rst_n), .csN(csN), .spc(spc), .sdi(sdi),
    .sdo(sdo), .sdoEn(sdoEn), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) regMem[i] <= 8'h00;
    end else if (regWrEn) begin
      regMem[regAddr] <= regWrData;
      wrCount <= wrCount + 1;
    end
  end
  assign regRdData = regMem[regAddr];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic halfP();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xferBits(input logic [7:0] tx, input int nBits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nBits; i--) begin
      spc = 1'b0;
      sdi = tx[i];
      halfP();
      rx[i] = sdo;
      enAny |= sdoEn;
      enAll &= sdoEn;
      spc = 1'b1;
      halfP();
    end
  endtask

  task automatic startF();
    csN = 1'b0;
    halfP();
  endtask

  task automatic endF();
    csN = 1'b1;
    repeat (4) halfP();
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + 5);
  endfunction

  initial begin
    logic [7:0] rx;
    int wc;
    for (int i = 0; i < 64; i++) expMem[i] = 8'h00;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(sdoEn == 1'b0, "R1 sdoEn", int'(sdoEn), 0);
    check(sdo == 1'b0, "R1 sdo", int'(sdo), 0);
    check(regWrEn == 1'b0, "R1 regWrEn", int'(regWrEn), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3: single write to every address, with R7 enable low during writes
    for (int a = 0; a < 64; a++) begin
      wc = wrCount;
      enAny = 1'b0;
      startF();
      xferBits({2'b00, 6'(a)}, 8, rx);
      xferBits(pat(a), 8, rx);
      endF();
      expMem[a] = pat(a);
      check(regMem[a] == expMem[a], "R3 write data", int'(regMem[a]), int'(expMem[a]));
      check(wrCount == wc + 1, "R3 write count", wrCount, wc + 1);
      check(enAny == 1'b0, "R7 no enable in write", int'(enAny), 0);
    end

    // R4: single read of every address. R2: a read makes no write. R7: enable high during data.
    for (int a = 0; a < 64; a++) begin
      wc = wrCount;
      enAny = 1'b0;
      startF();
      xferBits({2'b10, 6'(a)}, 8, rx);
      check(enAny == 1'b0, "R7 no enable in command", int'(enAny), 0);
      enAll = 1'b1;
      xferBits(8'h00, 8, rx);
      check(enAll == 1'b1, "R7 enable in read data", int'(enAll), 1);
      endF();
      check(rx == expMem[a], "R4 read data", int'(rx), int'(expMem[a]));
      check(wrCount == wc, "R2 read writes nothing", wrCount, wc);
      check(sdoEn == 1'b0 && sdo == 1'b0, "R7 idle after frame", int'(sdoEn), 0);
    end

    // R5: burst write from 62 wraps through 63 to 0 and 1
    startF();
    xferBits({2'b01, 6'd62}, 8, rx);
    for (int k = 0; k < 4; k++) begin
      xferBits(8'hA0 + 8'(k), 8, rx);
      expMem[(62 + k) % 64] = 8'hA0 + 8'(k);
    end
    endF();
    for (int k = 0; k < 4; k++)
      check(regMem[(62 + k) % 64] == expMem[(62 + k) % 64], "R5 burst write",
            int'(regMem[(62 + k) % 64]), int'(expMem[(62 + k) % 64]));

    // R5: burst read from 61 across the wrap
    startF();
    xferBits({2'b11, 6'd61}, 8, rx);
    for (int k = 0; k < 5; k++) begin
      xferBits(8'h00, 8, rx);
      check(rx == expMem[(61 + k) % 64], "R5 burst read", int'(rx), int'(expMem[(61 + k) % 64]));
    end
    endF();

    // R6: fixed-address writes land on one register
    wc = wrCount;
    startF();
    xferBits({2'b00, 6'd10}, 8, rx);
    xferBits(8'd11, 8, rx);
    xferBits(8'd22, 8, rx);
    xferBits(8'd33, 8, rx);
    endF();
    expMem[10] = 8'd33;
    check(regMem[10] == 8'd33, "R6 fixed write", int'(regMem[10]), 33);
    check(regMem[11] == expMem[11], "R6 neighbour untouched", int'(regMem[11]), int'(expMem[11]));
    check(wrCount == wc + 3, "R6 write count", wrCount, wc + 3);

    // R6: fixed-address reads repeat the same register
    startF();
    xferBits({2'b10, 6'd10}, 8, rx);
    for (int k = 0; k < 3; k++) begin
      xferBits(8'h00, 8, rx);
      check(rx == 8'd33, "R6 fixed read", int'(rx), 33);
    end
    endF();

    // R8: abort in the middle of a write data byte
    wc = wrCount;
    startF();
    xferBits({2'b00, 6'd20}, 8, rx);
    xferBits(8'hFF, 4, rx);
    endF();
    check(wrCount == wc, "R8 partial byte dropped", wrCount, wc);
    check(regMem[20] == expMem[20], "R8 register kept", int'(regMem[20]), int'(expMem[20]));

    // R8: abort in the command byte, then a clean read
    startF();
    xferBits(8'h00, 3, rx);
    endF();
    startF();
    xferBits({2'b10, 6'd20}, 8, rx);
    xferBits(8'h00, 8, rx);
    endF();
    check(rx == expMem[20], "R8 fresh frame read", int'(rx), int'(expMem[20]));
    check(wrCount == wc, "R8 no stray write", wrCount, wc);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule